// File: doc/BRIEF.md
# Pushed Compare Transfer Engine

This block lives inside a debug port, between the serial front end and an access port. The host programs a repeat count, a transfer mode, a compare mask and a start address through a small register-write port. A single host access then expands on chip into a run of bus accesses at the system clock rate, without waiting for the external link. In plain mode the run fills memory with one value or reads a block. In the two pushed modes the data of the host write is never written anywhere. It is kept as a reference, and every read result is compared with it under the mask.

Verify mode stops on the first masked mismatch and find mode stops on the first masked match. Together they give verify, search-for-match and search-for-non-match. A trigger sets a sticky flag and records the address of the location that caused it. The host can then learn the outcome of a whole block from one status read. While the flag is set, host accesses are dropped. An abort input clears the flag and cancels any run in progress.

Top module: `pcmp_engine`

## Requirements
- R1: After reset the engine is idle: busy and bus_req are low, sticky_cmp is low, bus_addr is 0, the repeat count is 0, the mode is plain and the mask is all ones.
- R2: A register write with reg_sel 0 loads the repeat count from reg_wdata[11:0]. reg_sel 1 loads the mode from reg_wdata[1:0], where 0 and 3 mean plain, 1 means verify and 2 means find. reg_sel 2 loads the mask and reg_sel 3 loads the start address. Register writes are ignored while busy is high and in the cycle a host access is accepted.
- R3: A host access accepted while idle starts a run of max(count,1) bus accesses. The address steps by 4 after every acknowledged access and is kept after the run, and the count is 0 when the run ends.
- R4: In plain mode, a host write drives host_wdata to every location of the run, and a host read loads rd_data with each read result, so rd_data ends holding the last word read.
- R5: In verify or find mode, a host write is performed as reads (bus_wr low) and its data becomes the compare reference, so memory is left unchanged. A host read in these modes behaves as a plain read.
- R6: A compare looks only at bit positions where the mask holds a 1. Differences in the other bits never affect the result.
- R7: A read whose compare triggers (a mismatch in verify mode, a match in find mode) sets sticky_cmp, loads hit_addr with that access's address and ends the run after that access. A run without a trigger performs every access and leaves sticky_cmp low.
- R8: While sticky_cmp is high, host accesses are ignored: no bus request is made and busy stays low.
- R9: busy is high from the cycle after a host access is accepted until the cycle after the run's last acknowledge. A host access presented while busy is ignored.
- R10: When abort is high at a clock edge, after that edge busy and bus_req are low, sticky_cmp is clear and the count is 0.
- R11: bus_req stays high, with bus_addr and bus_wdata unchanged, until bus_ack is seen. The accesses of a run go to consecutive word addresses starting at the programmed address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe from the front end |
| reg_sel | input | 2 | Register selector: 0 count, 1 mode, 2 mask, 3 start address |
| reg_wdata | input | 32 | Register write data |
| host_req | input | 1 | Host access-port access strobe |
| host_wr | input | 1 | Host access is a write |
| host_wdata | input | 32 | Host write data, or the compare reference in pushed modes |
| abort | input | 1 | Clears the sticky flag and cancels a run |
| busy | output | 1 | A run is in progress |
| bus_req | output | 1 | Bus access request to the access port |
| bus_wr | output | 1 | Bus access is a write |
| bus_addr | output | 32 | Bus access address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus access completion |
| bus_rdata | input | 32 | Bus read data, valid with bus_ack |
| rd_data | output | 32 | Last word read by a run |
| sticky_cmp | output | 1 | A pushed compare has triggered |
| hit_addr | output | 32 | Address of the access that triggered |

## Verification
The assertions check, on every cycle, the bus handshake hold and the 4-byte address step. They also check that an abort leaves the engine idle with a clear flag, that a trigger leaves the flag set and the engine idle, that a set flag keeps the engine idle, and that register writes are locked during a run. Some behaviour depends on memory contents and on the whole run, and only the bench scenarios show it. This covers the number of accesses, where a run stops early, the recorded hit address, masked-off differences being ignored, memory being left untouched by pushed runs, and the count being 0 after a run or an abort.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;

  typedef enum logic [1:0] {
    XM_PLAIN     = 2'd0,
    XM_VERIFY    = 2'd1,
    XM_FIND      = 2'd2,
    XM_PLAIN_ALT = 2'd3
  } xfer_mode_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } sq_state_e;

  localparam logic [1:0] SEL_COUNT = 2'd0;
  localparam logic [1:0] SEL_MODE  = 2'd1;
  localparam logic [1:0] SEL_MASK  = 2'd2;
  localparam logic [1:0] SEL_BASE  = 2'd3;

endpackage

// File: rtl/pcmp_rstsync.sv
module pcmp_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_ns = sync_q[STAGES-1];

endmodule

// File: rtl/pcmp_cfg.sv
module pcmp_cfg
  import pcmp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              cfg_lock,
  output xfer_mode_e        mode,
  output logic [DATA_W-1:0] mask
);

  xfer_mode_e        mode_q, mode_d;
  logic [DATA_W-1:0] mask_q, mask_d;
  logic              mode_en, mask_en;

  always_comb begin
    mode_en = reg_we && !cfg_lock && (reg_sel == SEL_MODE);
    mask_en = reg_we && !cfg_lock && (reg_sel == SEL_MASK);
    mode_d  = xfer_mode_e'(reg_wdata[1:0]);
    mask_d  = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= XM_PLAIN;
      mask_q <= '1;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign mode = mode_q;
  assign mask = mask_q;

  // R2: configuration cannot move while the sequencer holds the lock
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && cfg_lock) |=> ($stable(mode_q) && $stable(mask_q)));

endmodule

// File: rtl/pcmp_cmp.sv
module pcmp_cmp
  import pcmp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              cmp_en,
  input  xfer_mode_e        mode,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] refv,
  input  logic [DATA_W-1:0] mask,
  output logic              trig
);

  logic [DATA_W-1:0] diff;
  logic              equal;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign diff[i] = (rdata[i] ^ refv[i]) & mask[i];
  end

  assign equal = ~|diff;

  always_comb begin
    unique case (mode)
      XM_VERIFY: trig = cmp_en & ~equal;
      XM_FIND:   trig = cmp_en &  equal;
      default:   trig = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcmp_seq.sv
module pcmp_seq
  import pcmp_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 12,
  parameter int ADDR_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              abort,
  input  xfer_mode_e        mode,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              trig,
  output logic              cfg_lock,
  output logic              cmp_en,
  output logic [DATA_W-1:0] refv,
  output logic              busy,
  output logic              bus_req,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              sticky,
  output logic [ADDR_W-1:0] hit_addr
);

  localparam logic [CNT_W-1:0]  CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(ADDR_STEP);

  sq_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              wr_q, wr_d;
  logic              cmp_q, cmp_d;
  logic [DATA_W-1:0] data_q;
  logic              sticky_q, sticky_d;
  logic [ADDR_W-1:0] hit_q;
  logic [DATA_W-1:0] rdat_q;

  logic pushed, start, beat;
  logic data_en, hit_en, rdat_en;

  always_comb begin
    pushed   = (mode == XM_VERIFY) || (mode == XM_FIND);
    start    = host_req && (state_q == SQ_IDLE) && !sticky_q && !abort;
    beat     = (state_q == SQ_RUN) && bus_ack && !abort;
    cfg_lock = (state_q == SQ_RUN) || start;
    data_en  = start;
    rdat_en  = beat && !wr_q;
    hit_en   = beat && cmp_q && trig;
  end

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    addr_d   = addr_q;
    wr_d     = wr_q;
    cmp_d    = cmp_q;
    sticky_d = sticky_q;
    if (abort) begin
      state_d  = SQ_IDLE;
      cnt_d    = '0;
      sticky_d = 1'b0;
    end else if (state_q == SQ_IDLE) begin
      if (start) begin
        state_d = SQ_RUN;
        wr_d    = host_wr && !pushed;
        cmp_d   = host_wr && pushed;
        if (cnt_q == '0) cnt_d = CNT_ONE;
      end else if (reg_we) begin
        if (reg_sel == SEL_COUNT) cnt_d  = reg_wdata[CNT_W-1:0];
        if (reg_sel == SEL_BASE)  addr_d = reg_wdata[ADDR_W-1:0];
      end
    end else if (beat) begin
      addr_d = addr_q + STEP;
      if (cmp_q && trig) begin
        sticky_d = 1'b1;
        cnt_d    = '0;
        state_d  = SQ_IDLE;
      end else begin
        cnt_d = cnt_q - CNT_ONE;
        if (cnt_q == CNT_ONE) state_d = SQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      cnt_q    <= '0;
      addr_q   <= '0;
      wr_q     <= 1'b0;
      cmp_q    <= 1'b0;
      data_q   <= '0;
      sticky_q <= 1'b0;
      hit_q    <= '0;
      rdat_q   <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      addr_q   <= addr_d;
      wr_q     <= wr_d;
      cmp_q    <= cmp_d;
      sticky_q <= sticky_d;
      if (data_en) data_q <= host_wdata;
      if (hit_en)  hit_q  <= addr_q;
      if (rdat_en) rdat_q <= bus_rdata;
    end
  end

  assign busy      = (state_q == SQ_RUN);
  assign bus_req   = (state_q == SQ_RUN);
  assign bus_wr    = wr_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = data_q;
  assign refv      = data_q;
  assign cmp_en    = cmp_q && bus_ack;
  assign rd_data   = rdat_q;
  assign sticky    = sticky_q;
  assign hit_addr  = hit_q;

  // R10: abort returns the engine to idle with the flag clear
  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !bus_req && !sticky_q));

  // R8: a set flag keeps the engine from starting
  p_sticky_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && !busy && !abort) |=> !busy);

  // R11: request and its payload hold until acknowledged
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !abort) |=>
      (bus_req && $stable(bus_addr) && $stable(bus_wdata)));

  // R3: every acknowledged access advances the address by one word
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && !abort) |=> (bus_addr == $past(bus_addr) + STEP));

  // R7: a trigger ends the run and raises the flag
  p_trig_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && cmp_q && bus_ack && trig && !abort) |=> (sticky_q && !busy));

  // R5: pushed runs never write the bus
  p_push_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && host_wr && pushed) |=> !bus_wr);

endmodule

// File: rtl/pcmp_engine.sv
module pcmp_engine
  import pcmp_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 12,
  parameter int ADDR_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              abort,
  output logic              busy,
  output logic              bus_req,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              sticky_cmp,
  output logic [ADDR_W-1:0] hit_addr
);

  logic              rst_ns;
  xfer_mode_e        mode;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] refv;
  logic              cfg_lock, cmp_en, trig;

  pcmp_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  pcmp_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_ns), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cfg_lock(cfg_lock), .mode(mode), .mask(mask)
  );

  pcmp_cmp #(.DATA_W(DATA_W)) u_cmp (
    .cmp_en(cmp_en), .mode(mode), .rdata(bus_rdata), .refv(refv),
    .mask(mask), .trig(trig)
  );

  pcmp_seq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ADDR_STEP(ADDR_STEP)
  ) u_seq (
    .clk(clk), .rst_n(rst_ns), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .host_req(host_req), .host_wr(host_wr),
    .host_wdata(host_wdata), .abort(abort), .mode(mode),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .trig(trig),
    .cfg_lock(cfg_lock), .cmp_en(cmp_en), .refv(refv), .busy(busy),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .sticky(sticky_cmp),
    .hit_addr(hit_addr)
  );

endmodule

// File: tb/pcmp_engine_tb.sv
module pcmp_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic        abort = 1'b0;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        busy, bus_req, bus_wr, sticky_cmp;
  logic [31:0] bus_addr, bus_wdata, rd_data, hit_addr;

  always #2 clk = ~clk;

  pcmp_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .host_req(host_req), .host_wr(host_wr),
    .host_wdata(host_wdata), .abort(abort), .busy(busy), .bus_req(bus_req),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .rd_data(rd_data),
    .sticky_cmp(sticky_cmp), .hit_addr(hit_addr)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] mem [0:63];
  logic [31:0] alog [0:31];
  int n_acc = 0;
  int dly = 0;
  bit busy_after_req;

  // bus slave model: variable latency, one-cycle acknowledge
  always @(negedge clk) begin
    if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_req) begin
      if (dly == 0) begin
        if (bus_wr) mem[bus_addr[7:2]] = bus_wdata;
        bus_rdata = mem[bus_addr[7:2]];
        bus_ack = 1'b1;
        if (n_acc < 32) alog[n_acc] = bus_addr;
        n_acc++;
        dly = int'($urandom % 3);
      end else begin
        dly--;
      end
    end
  end

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic setup(input logic [1:0] md, input logic [31:0] mk,
                       input logic [31:0] cnt, input logic [31:0] base);
    wr_reg(2'd1, {30'd0, md});
    wr_reg(2'd2, mk);
    wr_reg(2'd0, cnt);
    wr_reg(2'd3, base);
  endtask

  task automatic do_run(input logic wr, input logic [31:0] d);
    int guard;
    n_acc = 0;
    @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
    busy_after_req = busy;
    guard = 0;
    while (busy && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic pulse_abort();
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
  endtask

  task automatic predict(input logic [1:0] md, input logic [31:0] mk,
                         input logic [31:0] rf, input logic [31:0] bs,
                         input int n, output bit h, output logic [31:0] ha,
                         output int na);
    h = 1'b0; ha = '0; na = n;
    for (int i = 0; i < n; i++) begin
      logic [31:0] a;
      bit m, t;
      a = bs + 32'(4 * i);
      m = (((mem[a[7:2]] ^ rf) & mk) == 32'd0);
      t = (md == 2'd1) ? !m : m;
      if (t) begin
        h = 1'b1; ha = a; na = i + 1;
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    bit h;
    logic [31:0] ha;
    int na;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 64; i++) mem[i] = 32'h1000_0000 + 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_eq("R1", "busy", {31'd0, busy}, 32'd0);
    check_eq("R1", "bus_req", {31'd0, bus_req}, 32'd0);
    check_eq("R1", "sticky", {31'd0, sticky_cmp}, 32'd0);
    check_eq("R1", "bus_addr", bus_addr, 32'd0);
    do_run(1'b0, 32'd0);
    check_eq("R1", "reset count gives single access", 32'(n_acc), 32'd1);

    // R3 R4 single plain write
    setup(2'd0, 32'hFFFF_FFFF, 32'd0, 32'h10);
    do_run(1'b1, 32'hA5A5_0001);
    check_eq("R3", "single access count", 32'(n_acc), 32'd1);
    check_eq("R4", "single write data", mem[4], 32'hA5A5_0001);
    check_eq("R3", "address after single", bus_addr, 32'h14);
    check_eq("R9", "busy after accept", {31'd0, busy_after_req}, 32'd1);

    // R3 R4 R11 block fill
    setup(2'd0, 32'hFFFF_FFFF, 32'd5, 32'h40);
    do_run(1'b1, 32'h0000_1234);
    check_eq("R3", "fill access count", 32'(n_acc), 32'd5);
    for (int i = 0; i < 5; i++) begin
      check_eq("R4", "fill word", mem[16 + i], 32'h0000_1234);
      check_eq("R11", "fill address order", alog[i], 32'h40 + 32'(4 * i));
    end
    check_eq("R3", "address after fill", bus_addr, 32'h54);
    do_run(1'b1, 32'h0000_7777);
    check_eq("R3", "count cleared after run", 32'(n_acc), 32'd1);

    // R4 plain block read
    setup(2'd0, 32'hFFFF_FFFF, 32'd3, 32'h80);
    do_run(1'b0, 32'd0);
    check_eq("R4", "read access count", 32'(n_acc), 32'd3);
    check_eq("R4", "last read data", rd_data, mem[34]);

    // R5 R7 verify, all locations match
    for (int i = 0; i < 4; i++) mem[8 + i] = 32'hCAFE_0000;
    setup(2'd1, 32'hFFFF_FFFF, 32'd4, 32'h20);
    do_run(1'b1, 32'hCAFE_0000);
    check_eq("R7", "verify pass sticky", {31'd0, sticky_cmp}, 32'd0);
    check_eq("R7", "verify pass accesses", 32'(n_acc), 32'd4);

    // R5 reference must not be written
    for (int i = 0; i < 4; i++) mem[8 + i] = 32'h0000_0055;
    setup(2'd1, 32'h0000_00F0, 32'd4, 32'h20);
    do_run(1'b1, 32'hFFFF_FF5A);
    check_eq("R5", "memory untouched", mem[9], 32'h0000_0055);
    check_eq("R6", "unmasked difference ignored", {31'd0, sticky_cmp}, 32'd0);
    check_eq("R6", "full run when masked equal", 32'(n_acc), 32'd4);

    // R7 verify mismatch in a masked bit at third location
    mem[10] = 32'h0000_0155;
    setup(2'd1, 32'h0000_0FF0, 32'd4, 32'h20);
    do_run(1'b1, 32'h0000_0055);
    check_eq("R7", "mismatch sets sticky", {31'd0, sticky_cmp}, 32'd1);
    check_eq("R7", "hit address", hit_addr, 32'h28);
    check_eq("R7", "early stop accesses", 32'(n_acc), 32'd3);
    check_eq("R7", "address after stop", bus_addr, 32'h2C);

    // R8 host access ignored while sticky
    do_run(1'b1, 32'h0000_0055);
    check_eq("R8", "no bus access", 32'(n_acc), 32'd0);
    check_eq("R8", "busy stays low", {31'd0, busy_after_req}, 32'd0);

    // R10 abort clears sticky
    pulse_abort();
    check_eq("R10", "abort clears sticky", {31'd0, sticky_cmp}, 32'd0);

    // R5 host read in pushed mode is a plain read
    setup(2'd1, 32'hFFFF_FFFF, 32'd2, 32'h80);
    do_run(1'b0, 32'd0);
    check_eq("R5", "pushed-mode read accesses", 32'(n_acc), 32'd2);
    check_eq("R5", "pushed-mode read data", rd_data, mem[33]);
    check_eq("R5", "pushed-mode read no sticky", {31'd0, sticky_cmp}, 32'd0);

    // R7 find mode
    for (int i = 0; i < 6; i++) mem[40 + i] = 32'h00AB_0000 + 32'(i);
    setup(2'd2, 32'h0000_FFFF, 32'd6, 32'hA0);
    do_run(1'b1, 32'hFF00_0003);
    check_eq("R7", "find sets sticky", {31'd0, sticky_cmp}, 32'd1);
    check_eq("R7", "find hit address", hit_addr, 32'hAC);
    check_eq("R7", "find accesses", 32'(n_acc), 32'd4);
    pulse_abort();

    // R2 R9 register and host writes ignored while busy
    setup(2'd0, 32'hFFFF_FFFF, 32'd6, 32'h100);
    n_acc = 0;
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b0;
    @(negedge clk);
    host_req = 1'b0;
    reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 32'd9;
    @(negedge clk);
    reg_we = 1'b0;
    host_req = 1'b1;
    @(negedge clk);
    host_req = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    check_eq("R9", "host access during run ignored", 32'(n_acc), 32'd6);
    do_run(1'b0, 32'd0);
    check_eq("R2", "count write during run ignored", 32'(n_acc), 32'd1);

    // R10 abort in the middle of a run
    setup(2'd0, 32'hFFFF_FFFF, 32'd10, 32'h0);
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b0;
    @(negedge clk);
    host_req = 1'b0;
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check_eq("R10", "busy low after abort", {31'd0, busy}, 32'd0);
    check_eq("R10", "bus_req low after abort", {31'd0, bus_req}, 32'd0);
    repeat (2) @(negedge clk);
    do_run(1'b0, 32'd0);
    check_eq("R10", "count zero after abort", 32'(n_acc), 32'd1);

    // R6 R7 random pushed runs against the bench model
    for (int it = 0; it < 24; it++) begin
      logic [1:0]  md;
      logic [31:0] mk, rf, bs;
      int          cnt;
      md  = (it % 2 == 0) ? 2'd1 : 2'd2;
      mk  = $urandom;
      rf  = $urandom;
      cnt = 1 + int'($urandom % 8);
      bs  = 32'(($urandom % 48) * 4);
      for (int k = 0; k < 8; k++) begin
        int sel;
        sel = int'($urandom % 4);
        if (sel == 0)      mem[bs[7:2] + 6'(k)] = rf;
        else if (sel == 1) mem[bs[7:2] + 6'(k)] = rf ^ (32'd1 << ($urandom % 32));
        else               mem[bs[7:2] + 6'(k)] = $urandom;
      end
      setup(md, mk, 32'(cnt), bs);
      predict(md, mk, rf, bs, cnt, h, ha, na);
      do_run(1'b1, rf);
      check_eq("R7", "random sticky", {31'd0, sticky_cmp}, {31'd0, h});
      check_eq("R6", "random accesses", 32'(n_acc), 32'(na));
      if (h) check_eq("R7", "random hit address", hit_addr, ha);
      pulse_abort();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule